// File: doc/BRIEF.md
# Single-Cycle Four-Instruction Processor

This block is a 32-bit processor core that fetches, decodes and completes one instruction on every clock edge. It recognises four operations from a classic three-register RISC encoding: register add, word load, word store and branch-if-equal. Every other encoding is treated as a no-op. The program counter, a 32-entry register file, an adder/subtractor with a zero detector, the immediate sign extender, the branch target adder, the selection multiplexers and the main decoder all sit inside the block.

Instruction memory and data memory are word arrays inside the block. A harness fills them through dedicated preload ports and can also preload the register file. It observes the results through combinational peek ports.

The intended use is as follows. Hold reset, load a program and its data through the preload ports, then release reset. The core then executes from byte address 0. Memory words are selected by address bits from bit 2 upward, and address bits above the array size are ignored.

Top module: `sc_quad_cpu`

## Requirements
- R1: While `rst` is high the program counter `pc` is 0. After release it advances by 4 on each rising edge unless a taken branch is executing.
- R2: Fields are located at opcode [31:26], first source [25:21], second source [20:16], destination [15:11], function [5:0] and immediate [15:0]. Opcode 0x00 with function 0x20 writes the 32-bit wrapping sum of the two sources into the destination register.
- R3: Opcode 0x23 forms the byte address source1 + sign-extended immediate. It writes the data-memory word at that address into the register named by bits [20:16]. Negative immediates are allowed.
- R4: Opcode 0x2B stores the register named by bits [20:16] into the data-memory word at source1 + sign-extended immediate. It never writes the register file.
- R5: Opcode 0x04 with equal sources sets the next PC to PC + 4 + (sign-extended immediate × 4). A negative immediate branches backwards. A branch writes neither the register file nor data memory.
- R6: Opcode 0x04 with unequal sources continues at PC + 4.
- R7: Register 0 always reads as 0. Adds, loads and preloads aimed at it leave it at 0.
- R8: Any other opcode, or opcode 0x00 with a function other than 0x20, changes no register and no memory word and advances the PC by 4.
- R9: Preload writes take effect on the rising edge whether or not reset is asserted, and they take priority over core writes. The peek ports read combinationally.
- R10: The four-instruction program "beq r16,r0,+3; lw r8,4(r17); add r8,r8,r16; sw r8,0(r17)" updates the word at r17 to (word at r17+4) + r16 only when r16 is non-zero. When r16 is zero it leaves that word and r8 untouched and reaches byte address 16 after one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the PC; gates core writes |
| imem_ld_we | input | 1 | Instruction memory preload strobe |
| imem_ld_addr | input | IAW | Instruction word index for preload |
| imem_ld_data | input | 32 | Instruction word to preload |
| dmem_ld_we | input | 1 | Data memory preload strobe |
| dmem_ld_addr | input | DAW | Data word index for preload |
| dmem_ld_data | input | 32 | Data word to preload |
| reg_ld_we | input | 1 | Register preload strobe |
| reg_ld_addr | input | 5 | Register index for preload |
| reg_ld_data | input | 32 | Register value to preload |
| dmem_pk_addr | input | DAW | Data word index to observe |
| dmem_pk_data | output | 32 | Data word at `dmem_pk_addr` |
| reg_pk_addr | input | 5 | Register index to observe |
| reg_pk_data | output | 32 | Register value at `reg_pk_addr` |
| pc | output | 32 | Current program counter (byte address) |

## Verification
The assertions check several properties on every executed instruction: sequential PC stepping, the exact taken-branch target, the zero reading of register 0, the absence of register writes on stores and branches, data-memory writes occurring only on stores, and no side effects for unrecognised encodings. Only the bench scenarios can show the arithmetic results that land in registers and memory. They also show load/store addressing with positive and negative offsets, the preload priority, and the end-to-end conditional update of the sample program across a sweep of register values, including zero, sign-boundary and all-ones values.

// File: rtl/scq_pkg.sv
package scq_pkg;
    localparam int XLEN = 32;
    localparam int RAW  = 5;
    localparam int NREG = 1 << RAW;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADD   = 6'h20;

    typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    wb_from_mem;
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]  opcode;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [4:0]  shamt;
        logic [5:0]  funct;
    } rfmt_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] branch_offset(input logic [15:0] v);
        return {sext16(v)[XLEN-3:0], 2'b00};
    endfunction
endpackage

// File: rtl/scq_decoder.sv
module scq_decoder
    import scq_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctl
);
    rfmt_t f;
    assign f = rfmt_t'(instr);

    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (f.opcode)
            OP_RTYPE: begin
                if (f.funct == FN_ADD) begin
                    ctl.dst_is_rd = 1'b1;
                    ctl.reg_write = 1'b1;
                end
            end
            OP_LOAD: begin
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_write   = 1'b1;
                ctl.mem_read    = 1'b1;
            end
            OP_STORE: begin
                ctl.b_is_imm  = 1'b1;
                ctl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/scq_regfile.sv
module scq_regfile
    import scq_pkg::*;
(
    input  logic            clk,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd,
    input  logic            pl_we,
    input  logic [RAW-1:0]  pl_a,
    input  logic [XLEN-1:0] pl_d,
    input  logic [RAW-1:0]  pk_a,
    output logic [XLEN-1:0] pk_d
);
    logic [XLEN-1:0] regs [NREG];

    assign regs[0] = '0;

    for (genvar r = 1; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (pl_we && pl_a == RAW'(r))
                regs[r] <= pl_d;
            else if (we && wa == RAW'(r))
                regs[r] <= wd;
        end
    end

    assign rd1  = regs[ra1];
    assign rd2  = regs[ra2];
    assign pk_d = regs[pk_a];
endmodule

// File: rtl/scq_alu.sv
module scq_alu
    import scq_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_quad_cpu.sv
module sc_quad_cpu
    import scq_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            imem_ld_we,
    input  logic [IAW-1:0]  imem_ld_addr,
    input  logic [31:0]     imem_ld_data,
    input  logic            dmem_ld_we,
    input  logic [DAW-1:0]  dmem_ld_addr,
    input  logic [31:0]     dmem_ld_data,
    input  logic            reg_ld_we,
    input  logic [4:0]      reg_ld_addr,
    input  logic [31:0]     reg_ld_data,
    input  logic [DAW-1:0]  dmem_pk_addr,
    output logic [31:0]     dmem_pk_data,
    input  logic [4:0]      reg_pk_addr,
    output logic [31:0]     reg_pk_data,
    output logic [31:0]     pc
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
    logic [XLEN-1:0] instr;
    rfmt_t           f;
    ctrl_t           ctl;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data, mem_rdata;
    logic            alu_zero, take_br, rf_we, dmem_we;
    logic [RAW-1:0]  wb_addr;
    logic [DAW-1:0]  daddr;

    // Fetch
    assign instr = imem[pc_q[IAW+1:2]];
    assign f     = rfmt_t'(instr);

    always_ff @(posedge clk) begin
        if (imem_ld_we)
            imem[imem_ld_addr] <= imem_ld_data;
    end

    // Decode
    scq_decoder i_dec (.instr(instr), .ctl(ctl));

    scq_regfile i_rf (
        .clk  (clk),
        .ra1  (f.rs),
        .ra2  (f.rt),
        .rd1  (rs_val),
        .rd2  (rt_val),
        .we   (rf_we),
        .wa   (wb_addr),
        .wd   (wb_data),
        .pl_we(reg_ld_we),
        .pl_a (reg_ld_addr),
        .pl_d (reg_ld_data),
        .pk_a (reg_pk_addr),
        .pk_d (reg_pk_data)
    );

    // Execute
    assign imm_ext = sext16(instr[15:0]);
    assign alu_b   = ctl.b_is_imm ? imm_ext : rt_val;

    scq_alu i_alu (
        .a   (rs_val),
        .b   (alu_b),
        .op  (ctl.alu_op),
        .y   (alu_y),
        .zero(alu_zero)
    );

    // Memory
    assign daddr     = alu_y[DAW+1:2];
    assign mem_rdata = dmem[daddr];
    assign dmem_we   = ctl.mem_write & ~rst;

    always_ff @(posedge clk) begin
        if (dmem_ld_we)
            dmem[dmem_ld_addr] <= dmem_ld_data;
        else if (dmem_we)
            dmem[daddr] <= rt_val;
    end
    assign dmem_pk_data = dmem[dmem_pk_addr];

    // Write back
    assign wb_addr = ctl.dst_is_rd ? f.rd : f.rt;
    assign wb_data = ctl.wb_from_mem ? mem_rdata : alu_y;
    assign rf_we   = ctl.reg_write & ~rst;

    // Next PC
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + branch_offset(instr[15:0]);
    assign take_br   = ctl.branch & alu_zero;
    assign pc_next   = take_br ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end
    assign pc = pc_q;
endmodule

// File: rtl/scq_checker.sv
module scq_checker
    import scq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] instr,
    input ctrl_t           ctl,
    input logic [XLEN-1:0] rs_val,
    input logic            take_br,
    input logic            rf_we,
    input logic            dmem_we
);
    logic known;
    assign known = (instr[31:26] == OP_LOAD) || (instr[31:26] == OP_STORE) ||
                   (instr[31:26] == OP_BEQ) ||
                   (instr[31:26] == OP_RTYPE && instr[5:0] == FN_ADD);

    assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> pc_q == $past(pc_q) + 32'd4);

    assert_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
        take_br |=> pc_q == $past(pc_q) + 32'd4 +
                            {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    assert_no_wb_on_store_branch_R4: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OP_STORE || instr[31:26] == OP_BEQ) |-> !rf_we);

    assert_dmem_write_only_store_R4: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> instr[31:26] == OP_STORE);

    assert_reg0_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> rs_val == '0);

    assert_unknown_noop_R8: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!rf_we && !dmem_we && !take_br));

    assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_read && ctl.mem_write));
endmodule

bind sc_quad_cpu scq_checker i_chk (
    .clk    (clk),
    .rst    (rst),
    .pc_q   (pc_q),
    .instr  (instr),
    .ctl    (ctl),
    .rs_val (rs_val),
    .take_br(take_br),
    .rf_we  (rf_we),
    .dmem_we(dmem_we)
);

// File: tb/test_sc_quad_cpu.sv
module test_sc_quad_cpu;
    localparam int IW = 64, DW = 64;
    localparam int IAW = $clog2(IW), DAW = $clog2(DW);

    logic clk = 0, rst = 1;
    logic imem_ld_we = 0, dmem_ld_we = 0, reg_ld_we = 0;
    logic [IAW-1:0] imem_ld_addr = '0;
    logic [DAW-1:0] dmem_ld_addr = '0, dmem_pk_addr = '0;
    logic [31:0] imem_ld_data = '0, dmem_ld_data = '0, reg_ld_data = '0;
    logic [4:0] reg_ld_addr = '0, reg_pk_addr = '0;
    logic [31:0] dmem_pk_data, reg_pk_data, pc;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sc_quad_cpu #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_sc_quad_cpu (.*);

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ld_imem(int a, logic [31:0] d);
        imem_ld_addr = IAW'(a); imem_ld_data = d; imem_ld_we = 1;
        @(posedge clk); #1 imem_ld_we = 0;
    endtask
    task automatic ld_dmem(int a, logic [31:0] d);
        dmem_ld_addr = DAW'(a); dmem_ld_data = d; dmem_ld_we = 1;
        @(posedge clk); #1 dmem_ld_we = 0;
    endtask
    task automatic ld_reg(int a, logic [31:0] d);
        reg_ld_addr = 5'(a); reg_ld_data = d; reg_ld_we = 1;
        @(posedge clk); #1 reg_ld_we = 0;
    endtask
    task automatic pk_reg(int a, output logic [31:0] d);
        reg_pk_addr = 5'(a); #1 d = reg_pk_data;
    endtask
    task automatic pk_dmem(int a, output logic [31:0] d);
        dmem_pk_addr = DAW'(a); #1 d = dmem_pk_data;
    endtask
    task automatic clear_imem();
        for (int i = 0; i < IW; i++) ld_imem(i, 32'h0);
    endtask
    task automatic start();
        @(negedge clk); rst = 0; #1;
        check("R1 pc zero at start", pc, 32'h0);
    endtask
    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h5, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};

    initial begin
        logic [31:0] v, d;
        // R10/R5/R6 sweep over the sample program
        for (int vi = 0; vi < 6; vi++) begin
            for (int bi = 0; bi < 2; bi++) begin
                int base;
                logic [31:0] m, exp_word, exp_r8;
                base = 16 + 8 * bi;
                v = vals[vi];
                m = 32'd100 + 32'(vi * 7 + bi);
                rst = 1;
                clear_imem();
                ld_imem(0, enc_i(6'h04, 5'd16, 5'd0, 16'd3));
                ld_imem(1, enc_i(6'h23, 5'd17, 5'd8, 16'd4));
                ld_imem(2, enc_r(5'd8, 5'd16, 5'd8, 6'h20));
                ld_imem(3, enc_i(6'h2B, 5'd17, 5'd8, 16'd0));
                ld_imem(4, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));
                ld_reg(16, v);
                ld_reg(17, 32'(base * 4));
                ld_reg(8, 32'h55);
                ld_dmem(base + 1, m);
                ld_dmem(base, 32'hDEAD);
                pk_reg(16, d); check("R9 preload in reset", d, v);
                start();
                step(1);
                check("R5/R6 pc after beq", pc, (v == 0) ? 32'd16 : 32'd4);
                step(4);
                exp_word = (v == 0) ? 32'hDEAD : m + v;
                exp_r8   = (v == 0) ? 32'h55   : m + v;
                pk_dmem(base, d); check("R10 a[0] conditional update", d, exp_word);
                pk_reg(8, d);     check("R3/R2 r8 value", d, exp_r8);
                check("R5 backward loop holds pc", pc, 32'd16);
            end
        end

        // Misc program: R2, R3, R4, R6, R7, R8, negative offsets
        rst = 1;
        clear_imem();
        ld_imem(0, enc_r(5'd1, 5'd2, 5'd0, 6'h20));          // add r0 (ignored)
        ld_imem(1, enc_r(5'd1, 5'd2, 5'd3, 6'h20));          // r3 = 16
        ld_imem(2, {6'h3F, 5'd1, 5'd3, 16'h0001});           // unknown opcode
        ld_imem(3, enc_r(5'd1, 5'd2, 5'd4, 6'h22));          // unknown funct
        ld_imem(4, enc_i(6'h23, 5'd0, 5'd0, 16'd0));         // lw r0
        ld_imem(5, enc_i(6'h2B, 5'd5, 5'd3, 16'hFFFC));      // sw r3,-4(r5)
        ld_imem(6, enc_i(6'h23, 5'd5, 5'd6, 16'hFFFC));      // lw r6,-4(r5)
        ld_imem(7, enc_i(6'h04, 5'd1, 5'd2, 16'd5));         // not taken
        ld_imem(8, enc_i(6'h04, 5'd3, 5'd6, 16'hFFF8));      // back to 4
        ld_reg(1, 32'd7);
        ld_reg(2, 32'd9);
        ld_reg(3, 32'h33);
        ld_reg(4, 32'h44);
        ld_reg(5, 32'h48);
        ld_reg(6, 32'h0);
        ld_reg(0, 32'hABCD);
        ld_dmem(0, 32'h99);
        ld_dmem(17, 32'h0);
        pk_reg(0, d); check("R7 preload to r0 ignored", d, 32'h0);
        start();
        step(1);
        pk_reg(0, d); check("R7 add to r0 ignored", d, 32'h0);
        check("R1 pc step", pc, 32'd4);
        step(1);
        pk_reg(3, d); check("R2 add result", d, 32'd16);
        step(1);
        pk_reg(3, d); check("R8 unknown opcode no write", d, 32'd16);
        check("R8 unknown opcode pc+4", pc, 32'd12);
        step(1);
        pk_reg(4, d); check("R8 unknown funct no write", d, 32'h44);
        step(1);
        pk_reg(0, d); check("R7 load to r0 ignored", d, 32'h0);
        step(1);
        pk_dmem(17, d); check("R4 store negative offset", d, 32'd16);
        pk_reg(3, d);   check("R4 store keeps rt", d, 32'd16);
        step(1);
        pk_reg(6, d); check("R3 load negative offset", d, 32'd16);
        step(1);
        check("R6 not-taken pc", pc, 32'd32);
        step(1);
        check("R5 taken backward pc", pc, 32'd4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule